// File: doc/BRIEF.md
# Serial Port Interrupt Identification and Priority

This block sits beside the register bank of a 16550-style serial controller. It collects the interrupt causes reported by the receiver, the transmitter and the modem-status logic. It masks them with a four-bit enable register that it owns. It then drives one interrupt line and an eight-bit identification code that software reads to learn which cause to service.

Line errors, transmit-holding-empty and modem-status changes arrive as single-cycle event pulses. Each one is latched until the register access that services it. Received-data-available follows the receive FIFO's trigger-level flag directly.

The character timeout is produced inside the block. A counter advances on a character-time tick while the receive FIFO holds data. It expires when no character has arrived and no read has been made for a parameterised number of character times. The identification code always carries the two FIFO-enabled bits, and the interrupt line is the inverse of its bit 0.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification code is 0xC1, the interrupt line is low and all enables are clear.
- R2: Bits 7:6 of the identification code are always 1 and bits 5:4 always 0. Low nibble 0x1 means nothing pending, 0x6 line status, 0xC character timeout, 0x4 received data available, 0x2 transmit holding empty and 0x0 modem status.
- R3: When several enabled causes are pending, the one reported is chosen in this fixed order: line status, then character timeout, then received data, then transmit holding empty, then modem status.
- R4: The enable register is written whole from `ier_wdata` on `ier_wr`. Bit 0 enables received data and timeout, bit 1 enables transmit holding empty, bit 2 enables line status and bit 3 enables modem status. A disabled cause is not reported, but it stays latched and reappears once it is enabled again. Writing 0 gives code 0xC1 and a low line in the next cycle.
- R5: A pulse on `ev_line_err` latches the line-status cause. A line-status read (`rd_lsr`) clears it.
- R6: The received-data cause is pending in every cycle in which `rx_level_hit` is high. No access clears it directly.
- R7: The timeout counter restarts on `rx_push`, on `rd_rbr` and whenever `rx_nonempty` is low. Otherwise it counts `char_tick` pulses. On the 4th tick (the TO_CHARS default) the timeout cause becomes pending and counting stops. Only `rd_rbr` clears the timeout cause.
- R8: A pulse on `thr_drained` latches the transmit-holding-empty cause. A write of the holding register (`wr_thr`) clears it. An identification read (`rd_iir`) also clears it, but only in a cycle when it is the cause being reported; such a read has no effect on it otherwise.
- R9: A pulse on `ev_modem` latches the modem-status cause. A modem-status read (`rd_msr`) clears it.
- R10: The interrupt line equals the inverse of identification bit 0 in every cycle.
- R11: When a cause's set event and its clearing access happen in the same cycle, the cause ends up pending.
- R12: Every event and access takes effect on the code and the line in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 4 | Enable bits to write |
| ev_line_err | input | 1 | Pulse: receiver line error (break, framing, parity, overrun) |
| rx_level_hit | input | 1 | Level: receive FIFO at or above trigger level |
| rx_nonempty | input | 1 | Level: receive FIFO holds data |
| rx_push | input | 1 | Pulse: a character entered the receive FIFO |
| char_tick | input | 1 | Pulse: one character time elapsed |
| thr_drained | input | 1 | Pulse: transmit holding register became empty |
| ev_modem | input | 1 | Pulse: modem status input changed |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request |
| iir_byte | output | 8 | Identification code |

## Verification
The checker watches several properties on every cycle. It checks that the fixed upper bits of the code hold and that the interrupt line always mirrors identification bit 0. It checks that an enabled line error wins the very next cycle and that a line-status read or receive-buffer read removes its cause. It also checks that clearing the enables silences the output at once.

Some behaviour is shown only by the bench's scenarios, and checked by its cycle-level reference model under random traffic. This covers the full priority order among all five causes and the exact fourth-tick expiry of the timeout, including its restart on a push partway through. It also covers the rule that an identification read clears transmit-empty only while that cause is reported, and the retention of masked causes across re-enabling.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N = 4;
  // enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  // latched cause slots
  localparam int LAT_N     = 3;
  localparam int LAT_LINE  = 0;
  localparam int LAT_THRE  = 1;
  localparam int LAT_MODEM = 2;

  localparam logic [3:0] FIFO_MARK = 4'b1100;

  typedef enum logic [3:0] {
    ID_NONE    = 4'h1,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC,
    ID_RXDATA  = 4'h4,
    ID_THRE    = 4'h2,
    ID_MODEM   = 4'h0
  } irq_id_e;

  typedef struct packed {
    logic line;
    logic timeout;
    logic rxdata;
    logic thre;
    logic modem;
  } cause_t;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;

  // set wins over a clear in the same cycle
  always_comb begin
    pend_d = pend_o;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end
endmodule

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_nonempty_i,
  input  logic char_tick_i,
  input  logic rx_push_i,
  input  logic rx_read_i,
  output logic expired_o
);
  localparam int CW = (TO_CHARS > 1) ? $clog2(TO_CHARS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TO_CHARS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_d;
  logic          restart;

  assign restart = rx_push_i | rx_read_i | ~rx_nonempty_i;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = expired_o;
    if (rx_read_i) exp_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (char_tick_i && !expired_o) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      expired_o <= exp_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  cause_t  cause_i,
  output irq_id_e id_o
);
  always_comb begin
    if      (cause_i.line)    id_o = ID_LINE;
    else if (cause_i.timeout) id_o = ID_TIMEOUT;
    else if (cause_i.rxdata)  id_o = ID_RXDATA;
    else if (cause_i.thre)    id_o = ID_THRE;
    else if (cause_i.modem)   id_o = ID_MODEM;
    else                      id_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [SRC_N-1:0] ier_wdata,
  input  logic             ev_line_err,
  input  logic             rx_level_hit,
  input  logic             rx_nonempty,
  input  logic             rx_push,
  input  logic             char_tick,
  input  logic             thr_drained,
  input  logic             ev_modem,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic             irq,
  output logic [7:0]       iir_byte
);
  logic [SRC_N-1:0] ier_q, ier_d;
  logic [LAT_N-1:0] lat_set, lat_clr, lat_pend;
  logic             to_pend;
  cause_t           masked;
  irq_id_e          cur_id;

  // enable register
  always_comb ier_d = ier_wr ? ier_wdata : ier_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else        ier_q <= ier_d;
  end

  // set / clear wiring for latched causes
  always_comb begin
    lat_set[LAT_LINE]  = ev_line_err;
    lat_clr[LAT_LINE]  = rd_lsr;
    lat_set[LAT_THRE]  = thr_drained;
    lat_clr[LAT_THRE]  = wr_thr | (rd_iir & (cur_id == ID_THRE));
    lat_set[LAT_MODEM] = ev_modem;
    lat_clr[LAT_MODEM] = rd_msr;
  end

  for (genvar g = 0; g < LAT_N; g++) begin : g_lat
    irq_src_latch u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (lat_set[g]),
      .clr_i  (lat_clr[g]),
      .pend_o (lat_pend[g])
    );
  end

  rx_timeout_timer #(.TO_CHARS(TO_CHARS)) u_tmo (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_nonempty_i (rx_nonempty),
    .char_tick_i   (char_tick),
    .rx_push_i     (rx_push),
    .rx_read_i     (rd_rbr),
    .expired_o     (to_pend)
  );

  always_comb begin
    masked.line    = lat_pend[LAT_LINE]  & ier_q[EN_LINE];
    masked.timeout = to_pend             & ier_q[EN_RX];
    masked.rxdata  = rx_level_hit        & ier_q[EN_RX];
    masked.thre    = lat_pend[LAT_THRE]  & ier_q[EN_THRE];
    masked.modem   = lat_pend[LAT_MODEM] & ier_q[EN_MODEM];
  end

  irq_prio_enc u_enc (
    .cause_i (masked),
    .id_o    (cur_id)
  );

  assign iir_byte = {FIFO_MARK, cur_id};
  assign irq      = |masked;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier_q,
  input logic       ier_wr,
  input logic [3:0] ier_wdata,
  input logic       ev_line_err,
  input logic       rd_lsr,
  input logic       rd_rbr,
  input logic       irq,
  input logic [7:0] iir_byte
);
  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iir_byte[7:4] == 4'hC);

  p_irq_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ~iir_byte[0]);

  p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_line_err && ier_q[2] && !ier_wr) |=> (iir_byte == 8'hC6));

  p_lsr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ev_line_err) |=> (iir_byte != 8'hC6));

  p_mask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && ier_wdata == 4'h0) |=> (!irq && iir_byte == 8'hC1));

  p_timeout_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rbr |=> (iir_byte != 8'hCC));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ier_q       (ier_q),
  .ier_wr      (ier_wr),
  .ier_wdata   (ier_wdata),
  .ev_line_err (ev_line_err),
  .rd_lsr      (rd_lsr),
  .rd_rbr      (rd_rbr),
  .irq         (irq),
  .iir_byte    (iir_byte)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0; logic [3:0] ier_wdata = 0;
  logic ev_line_err = 0, rx_level_hit = 0, rx_nonempty = 0, rx_push = 0;
  logic char_tick = 0, thr_drained = 0, ev_modem = 0;
  logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, rd_msr = 0, wr_thr = 0;
  logic irq; logic [7:0] iir_byte;

  int n_chk = 0, n_err = 0;

  // reference state
  logic [3:0] m_ier; logic m_line, m_thre, m_modem, m_to; int m_cnt;

  always #2.5 clk = ~clk;

  uart_irq_ident u_dut (.*);

  function automatic logic [7:0] exp_code();
    logic r = m_ier[0];
    if (m_line & m_ier[2])       return 8'hC6;
    if (m_to & r)                return 8'hCC;
    if (rx_level_hit & r)        return 8'hC4;
    if (m_thre & m_ier[1])       return 8'hC2;
    if (m_modem & m_ier[3])      return 8'hC0;
    return 8'hC1;
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ier = 0; m_line = 0; m_thre = 0; m_modem = 0; m_to = 0; m_cnt = 0;
  endtask

  task automatic model_update();
    logic [7:0] old = exp_code();
    if (rd_lsr) m_line = 0;
    if (ev_line_err) m_line = 1;
    if (wr_thr || (rd_iir && old == 8'hC2)) m_thre = 0;
    if (thr_drained) m_thre = 1;
    if (rd_msr) m_modem = 0;
    if (ev_modem) m_modem = 1;
    if (rd_rbr) m_to = 0;
    if (rx_push || rd_rbr || !rx_nonempty) m_cnt = 0;
    else if (char_tick && !m_to) begin
      if (m_cnt == 3) begin m_cnt = 0; m_to = 1; end
      else m_cnt++;
    end
    if (ier_wr) m_ier = ier_wdata;
  endtask

  task automatic clr_strobes();
    ier_wr = 0; ev_line_err = 0; rx_push = 0; char_tick = 0; thr_drained = 0;
    ev_modem = 0; rd_lsr = 0; rd_rbr = 0; rd_iir = 0; rd_msr = 0; wr_thr = 0;
  endtask

  // one clock: model tracks the sampled inputs, compare 2 ns after the edge (R12)
  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    #2;
    chk(iir_byte, exp_code(), tag);
    chk({7'd0, irq}, {7'd0, ~iir_byte[0]}, "R10");
    clr_strobes();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    #12;
    chk(iir_byte, 8'hC1, "R1"); chk({7'd0, irq}, 8'd0, "R1");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk(iir_byte, 8'hC1, "R1");

    // R4 enable all
    ier_wr = 1; ier_wdata = 4'hF; step("R4");
    // R5 line error and clear
    ev_line_err = 1; step("R5"); chk(iir_byte, 8'hC6, "R5");
    rd_lsr = 1; step("R5"); chk(iir_byte, 8'hC1, "R5");
    // R8 thre cleared by iir read while reported
    thr_drained = 1; step("R8"); chk(iir_byte, 8'hC2, "R8");
    rd_iir = 1; step("R8"); chk(iir_byte, 8'hC1, "R8");
    thr_drained = 1; step("R8");
    wr_thr = 1; step("R8"); chk(iir_byte, 8'hC1, "R8");
    // R3 priority, iir read while thre hidden has no effect
    thr_drained = 1; ev_line_err = 1; step("R3"); chk(iir_byte, 8'hC6, "R3");
    rd_iir = 1; step("R8");
    rd_lsr = 1; step("R8"); chk(iir_byte, 8'hC2, "R8");
    // R6 data available over thre, under line
    rx_level_hit = 1; step("R6"); chk(iir_byte, 8'hC4, "R6");
    ev_line_err = 1; step("R3"); chk(iir_byte, 8'hC6, "R3");
    rd_lsr = 1; rx_level_hit = 0; step("R6"); chk(iir_byte, 8'hC2, "R6");
    wr_thr = 1; step("R8");
    // R7 timeout after four ticks, restart on push
    rx_nonempty = 1; rx_push = 1; step("R7");
    for (int i = 0; i < 3; i++) begin char_tick = 1; step("R7"); end
    chk(iir_byte, 8'hC1, "R7");
    rx_push = 1; step("R7");
    for (int i = 0; i < 3; i++) begin char_tick = 1; step("R7"); end
    chk(iir_byte, 8'hC1, "R7");
    char_tick = 1; step("R7"); chk(iir_byte, 8'hCC, "R7");
    rx_level_hit = 1; step("R3"); chk(iir_byte, 8'hCC, "R3");
    rd_rbr = 1; step("R7"); chk(iir_byte, 8'hC4, "R7");
    rx_level_hit = 0; rx_nonempty = 0; step("R7");
    // R9 modem
    ev_modem = 1; step("R9"); chk(iir_byte, 8'hC0, "R9");
    rd_msr = 1; step("R9"); chk(iir_byte, 8'hC1, "R9");
    // R11 set beats clear
    ev_line_err = 1; rd_lsr = 1; step("R11"); chk(iir_byte, 8'hC6, "R11");
    // R4 mask keeps latched causes
    ier_wr = 1; ier_wdata = 4'h0; step("R4"); chk(iir_byte, 8'hC1, "R4");
    chk({7'd0, irq}, 8'd0, "R4");
    ier_wr = 1; ier_wdata = 4'h4; step("R4"); chk(iir_byte, 8'hC6, "R4");
    rd_lsr = 1; step("R5");

    // random traffic against the reference model
    for (int k = 0; k < 3000; k++) begin
      ev_line_err = ($urandom_range(99) < 4);
      rd_lsr      = ($urandom_range(99) < 10);
      thr_drained = ($urandom_range(99) < 8);
      wr_thr      = ($urandom_range(99) < 5);
      rd_iir      = ($urandom_range(99) < 15);
      ev_modem    = ($urandom_range(99) < 4);
      rd_msr      = ($urandom_range(99) < 8);
      rx_push     = ($urandom_range(99) < 4);
      rd_rbr      = ($urandom_range(99) < 4);
      char_tick   = ($urandom_range(99) < 35);
      if ($urandom_range(99) < 5) rx_level_hit = ~rx_level_hit;
      if ($urandom_range(99) < 3) rx_nonempty = ~rx_nonempty;
      ier_wr      = ($urandom_range(99) < 3);
      ier_wdata   = 4'($urandom_range(15));
      step("R3");
    end
    finish_run();
  end
endmodule